// File: doc/BRIEF.md
# Paged MII-to-32-bit Register Bridge

This block lets a management host that only speaks 16-bit MII management transactions reach a 32-bit register bank. The bus side is already decoded: each access arrives as a PHY address, a register number, a direction and 16 bits of write data. A 9-bit page register sits at one fixed PHY/register pair and supplies the top of a 16-bit word index. The low three PHY address bits and the upper four register-number bits supply the rest of the index. Register-number bit 0 picks the lower half (even) or the upper half (odd) of the word.

Software writes the upper half first and then the lower half. The upper half is held in a shadow register. The lower-half write sends the full 32-bit word to the bank in a single strobe. Software reads the lower half first. That read fetches the whole word and keeps its upper half, so the upper-half read that follows returns a value from the same fetch.

The access input and the read response both use valid/ready. An access is taken only in a cycle where `acc_valid` and `acc_ready` are both high. `acc_ready` stays low while a bank transaction or an unaccepted response is outstanding. The response is only for reads. It holds `rsp_valid` and `rsp_data` until `rsp_ready` is seen. The bank request holds its address, direction and data until `bank_ready`. Read data comes back later on a `bank_rvalid` pulse.

Top module: `mii_reg_bridge`

## Requirements
- R1: A write to PHY address 0x1F, register 0x10 loads bits 8:0 of the write data into the page register. A read of that pair returns the page, zero-extended to 16 bits. The page is 0 after reset.
- R2: Every bank request carries the word index {page, PHY address bits 2:0, register bits 4:1}, with the page in the upper 9 bits.
- R3: A write to an odd register at PHY address 0x10 to 0x17 only updates the upper-half shadow. It issues no bank request.
- R4: A write to an even register at PHY address 0x10 to 0x17 issues exactly one bank write. Its data is {upper-half shadow, write data}.
- R5: A read of an even register at PHY address 0x10 to 0x17 issues exactly one bank read. It responds with bits 15:0 of the returned word.
- R6: A read of an odd register at PHY address 0x10 to 0x17 issues no bank request. It returns bits 31:16 of the word fetched by the most recent lower-half read.
- R7: A write to any PHY address outside 0x10 to 0x17, other than the page pair, has no effect. It causes no bank request and leaves the page unchanged.
- R8: A read of any PHY address outside 0x10 to 0x17, other than the page pair, responds with 0.
- R9: `acc_ready` is low while a bank request is outstanding or a response is pending. A waiting bank request keeps its fields stable. A waiting response keeps its data stable.
- R10: After reset, `acc_ready` is high and both `bank_req` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Management access offered |
| acc_ready | output | 1 | Bridge can take an access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_phy | input | 5 | PHY address of the access |
| acc_reg | input | 5 | Register number of the access |
| acc_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response available |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 16 | Read response data |
| bank_req | output | 1 | Bank request outstanding |
| bank_ready | input | 1 | Bank accepts the request |
| bank_we | output | 1 | Bank request is a write |
| bank_addr | output | 16 | Bank word index |
| bank_wdata | output | 32 | Bank write word |
| bank_rvalid | input | 1 | Bank read data valid (pulse) |
| bank_rdata | input | 32 | Bank read word |

## Verification
The assertions check the handshake rules on every cycle. They cover holding of bank requests and responses, and back-pressure while the bridge is busy. They also check, per access, whether a bank request follows an access, where the request's low address bits come from, and the zero reply for unmapped reads. Only the bench scenarios can show the multi-access behaviours. These are the pairing of the upper-half shadow with a later lower-half write, the upper half returned from an earlier fetch, the page reaching the bank address, and the page surviving ignored writes. The bench checks them against its own model of the page, the shadows and the bank contents.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
  localparam int PHY_W   = 5;
  localparam int REG_W   = 5;
  localparam int WIN_W   = 3;          // PHY address bits that select a word group
  localparam int SEL_W   = REG_W - 1;  // register bits that select a word in the group
  localparam int TAG_W   = PHY_W - WIN_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_REQ,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_RESP
  } mrb_state_e;
endpackage

// File: rtl/mrb_hold.sv
module mrb_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/mrb_decode.sv
module mrb_decode import mrb_pkg::*; #(
  parameter int               PAGE_W   = 9,
  parameter logic [PHY_W-1:0] PAGE_PHY = 5'h1F,
  parameter logic [REG_W-1:0] PAGE_REG = 5'h10,
  parameter logic [TAG_W-1:0] WIN_TAG  = 2'b10,
  localparam int              ADDR_W   = PAGE_W + WIN_W + SEL_W
) (
  input  logic [PHY_W-1:0]  phy,
  input  logic [REG_W-1:0]  regn,
  input  logic [PAGE_W-1:0] page,
  output logic              is_page,
  output logic              in_win,
  output logic              hi_half,
  output logic [ADDR_W-1:0] word_addr
);
  always_comb begin
    is_page   = (phy == PAGE_PHY) && (regn == PAGE_REG);
    in_win    = (phy[PHY_W-1:WIN_W] == WIN_TAG);
    hi_half   = regn[0];
    word_addr = {page, phy[WIN_W-1:0], regn[REG_W-1:1]};
  end
endmodule

// File: rtl/mrb_ctrl.sv
module mrb_ctrl import mrb_pkg::*; #(
  parameter int HALF_W = 16,
  parameter int PAGE_W = 9,
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic [HALF_W-1:0]   acc_wdata,
  input  logic                dec_page,
  input  logic                dec_win,
  input  logic                dec_hi,
  input  logic [ADDR_W-1:0]   dec_addr,
  input  logic [PAGE_W-1:0]   page_q,
  input  logic [HALF_W-1:0]   wsh_q,
  input  logic [HALF_W-1:0]   rsh_q,
  input  logic                bank_ready,
  input  logic                bank_rvalid,
  input  logic [HALF_W-1:0]   bank_rdata_lo,
  input  logic                rsp_ready,
  output logic                acc_ready,
  output logic                page_ld,
  output logic                wsh_ld,
  output logic                rsh_ld,
  output logic                bank_req,
  output logic                bank_we,
  output logic [ADDR_W-1:0]   bank_addr,
  output logic [2*HALF_W-1:0] bank_wdata,
  output logic                rsp_valid,
  output logic [HALF_W-1:0]   rsp_data
);
  localparam int PAD_W = HALF_W - PAGE_W;

  mrb_state_e state;
  logic       fire;
  logic       lo_word;

  always_comb begin
    acc_ready = (state == ST_IDLE);
    fire      = acc_valid && acc_ready;
    lo_word   = dec_win && !dec_hi;
    page_ld   = fire && acc_write && dec_page;
    wsh_ld    = fire && acc_write && dec_win && dec_hi;
    rsh_ld    = (state == ST_RD_WAIT) && bank_rvalid;
    bank_req  = (state == ST_WR_REQ) || (state == ST_RD_REQ);
    rsp_valid = (state == ST_RESP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bank_we    <= 1'b0;
      bank_addr  <= '0;
      bank_wdata <= '0;
      rsp_data   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (fire) begin
            if (acc_write) begin
              if (lo_word) begin
                bank_we    <= 1'b1;
                bank_addr  <= dec_addr;
                bank_wdata <= {wsh_q, acc_wdata};
                state      <= ST_WR_REQ;
              end
            end else if (lo_word) begin
              bank_we   <= 1'b0;
              bank_addr <= dec_addr;
              state     <= ST_RD_REQ;
            end else begin
              if (dec_page)     rsp_data <= {{PAD_W{1'b0}}, page_q};
              else if (dec_win) rsp_data <= rsh_q;
              else              rsp_data <= '0;
              state <= ST_RESP;
            end
          end
        end
        ST_WR_REQ:  if (bank_ready) state <= ST_IDLE;
        ST_RD_REQ:  if (bank_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (bank_rvalid) begin
            rsp_data <= bank_rdata_lo;
            state    <= ST_RESP;
          end
        end
        ST_RESP:    if (rsp_ready) state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mii_reg_bridge.sv
module mii_reg_bridge import mrb_pkg::*; #(
  parameter int               PAGE_W   = 9,
  parameter int               HALF_W   = 16,
  parameter logic [PHY_W-1:0] PAGE_PHY = 5'h1F,
  parameter logic [REG_W-1:0] PAGE_REG = 5'h10,
  parameter logic [TAG_W-1:0] WIN_TAG  = 2'b10
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              acc_valid,
  output logic                              acc_ready,
  input  logic                              acc_write,
  input  logic [PHY_W-1:0]                  acc_phy,
  input  logic [REG_W-1:0]                  acc_reg,
  input  logic [HALF_W-1:0]                 acc_wdata,
  output logic                              rsp_valid,
  input  logic                              rsp_ready,
  output logic [HALF_W-1:0]                 rsp_data,
  output logic                              bank_req,
  input  logic                              bank_ready,
  output logic                              bank_we,
  output logic [PAGE_W+WIN_W+SEL_W-1:0]     bank_addr,
  output logic [2*HALF_W-1:0]               bank_wdata,
  input  logic                              bank_rvalid,
  input  logic [2*HALF_W-1:0]               bank_rdata
);
  localparam int ADDR_W = PAGE_W + WIN_W + SEL_W;

  logic [PAGE_W-1:0] page_q;
  logic [HALF_W-1:0] wsh_q, rsh_q;
  logic              page_ld, wsh_ld, rsh_ld;
  logic              dec_page, dec_win, dec_hi;
  logic [ADDR_W-1:0] dec_addr;

  mrb_decode #(
    .PAGE_W(PAGE_W), .PAGE_PHY(PAGE_PHY), .PAGE_REG(PAGE_REG), .WIN_TAG(WIN_TAG)
  ) u_decode (
    .phy(acc_phy), .regn(acc_reg), .page(page_q),
    .is_page(dec_page), .in_win(dec_win), .hi_half(dec_hi), .word_addr(dec_addr)
  );

  mrb_hold #(.W(PAGE_W)) u_page (
    .clk(clk), .rst_n(rst_n), .ld(page_ld), .d(acc_wdata[PAGE_W-1:0]), .q(page_q)
  );

  mrb_hold #(.W(HALF_W)) u_wr_shadow (
    .clk(clk), .rst_n(rst_n), .ld(wsh_ld), .d(acc_wdata), .q(wsh_q)
  );

  mrb_hold #(.W(HALF_W)) u_rd_shadow (
    .clk(clk), .rst_n(rst_n), .ld(rsh_ld), .d(bank_rdata[2*HALF_W-1:HALF_W]), .q(rsh_q)
  );

  mrb_ctrl #(.HALF_W(HALF_W), .PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_wdata(acc_wdata),
    .dec_page(dec_page), .dec_win(dec_win), .dec_hi(dec_hi), .dec_addr(dec_addr),
    .page_q(page_q), .wsh_q(wsh_q), .rsh_q(rsh_q),
    .bank_ready(bank_ready), .bank_rvalid(bank_rvalid),
    .bank_rdata_lo(bank_rdata[HALF_W-1:0]), .rsp_ready(rsp_ready),
    .acc_ready(acc_ready), .page_ld(page_ld), .wsh_ld(wsh_ld), .rsh_ld(rsh_ld),
    .bank_req(bank_req), .bank_we(bank_we), .bank_addr(bank_addr),
    .bank_wdata(bank_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/mii_reg_bridge_chk.sv
module mii_reg_bridge_chk import mrb_pkg::*; #(
  parameter int PAGE_W = 9,
  parameter int HALF_W = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          acc_valid,
  input logic                          acc_ready,
  input logic                          acc_write,
  input logic [PHY_W-1:0]              acc_phy,
  input logic [REG_W-1:0]              acc_reg,
  input logic                          bank_req,
  input logic                          bank_ready,
  input logic                          bank_we,
  input logic [PAGE_W+WIN_W+SEL_W-1:0] bank_addr,
  input logic [2*HALF_W-1:0]           bank_wdata,
  input logic                          rsp_valid,
  input logic                          rsp_ready,
  input logic [HALF_W-1:0]             rsp_data
);
  logic take, win, pg;
  always_comb begin
    take = acc_valid && acc_ready;
    win  = (acc_phy[PHY_W-1:WIN_W] == 2'b10);
    pg   = (acc_phy == 5'h1F) && (acc_reg == 5'h10);
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bank_req && !bank_ready |=> bank_req && $stable(bank_addr) && $stable(bank_we) && $stable(bank_wdata)); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R9
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_req || rsp_valid) |-> !acc_ready); // R9
  AST_HI_WRITE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    take && acc_write && win && acc_reg[0] |=> !bank_req); // R3
  AST_LO_WRITE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    take && acc_write && win && !acc_reg[0] |=> bank_req && bank_we); // R4
  AST_LO_READ_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    take && !acc_write && win && !acc_reg[0] |=> bank_req && !bank_we); // R5
  AST_LOW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    take && win && !acc_reg[0] |=>
      bank_addr[WIN_W+SEL_W-1:0] == {$past(acc_phy[WIN_W-1:0]), $past(acc_reg[REG_W-1:1])}); // R2
  AST_HI_READ_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    take && !acc_write && win && acc_reg[0] |=> rsp_valid && !bank_req); // R6
  AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    take && !win |=> !bank_req); // R7
  AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    take && !acc_write && !win && !pg |=> rsp_valid && (rsp_data == '0)); // R8
endmodule

bind mii_reg_bridge mii_reg_bridge_chk #(.PAGE_W(PAGE_W), .HALF_W(HALF_W)) u_chk (.*);

// File: tb/mii_reg_bridge_bench.sv
module mii_reg_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [4:0]  acc_phy = '0, acc_reg = '0;
  logic [15:0] acc_wdata = '0;
  logic        acc_ready, rsp_valid, bank_req, bank_we;
  logic        rsp_ready = 1'b0, bank_ready = 1'b0, bank_rvalid = 1'b0;
  logic [15:0] rsp_data, bank_addr;
  logic [31:0] bank_wdata, bank_rdata = '0;

  int checks = 0, errors = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [15:0] last_wr_addr = '0, last_rd_addr = '0;
  logic [31:0] last_wr_data = '0;
  logic [31:0] mem [int];
  logic [8:0]  page_m = '0;
  logic [15:0] wsh_m = '0, rsh_m = '0;

  always #10 clk = ~clk;

  mii_reg_bridge u_mii_reg_bridge (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_write(acc_write), .acc_phy(acc_phy), .acc_reg(acc_reg), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .bank_req(bank_req), .bank_ready(bank_ready), .bank_we(bank_we),
    .bank_addr(bank_addr), .bank_wdata(bank_wdata),
    .bank_rvalid(bank_rvalid), .bank_rdata(bank_rdata)
  );

  function automatic logic [31:0] mem_val(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return {a ^ 16'h5A3C, ~a};
  endfunction

  function automatic logic [15:0] word_of(input logic [4:0] p, input logic [4:0] r);
    return {page_m, p[2:0], r[4:1]};
  endfunction

  // bank responder: handshake seen at a posedge is settled at the following negedge
  logic        prev_req = 1'b0, prev_we = 1'b0;
  logic [15:0] prev_addr = '0;
  logic [31:0] prev_wd = '0;
  always @(negedge clk) begin
    bank_rvalid = 1'b0;
    if (rst_n && prev_req && bank_ready) begin
      if (prev_we) begin
        mem[int'(prev_addr)] = prev_wd;
        wr_cnt++;
        last_wr_addr = prev_addr;
        last_wr_data = prev_wd;
      end else begin
        bank_rvalid = 1'b1;
        bank_rdata  = mem_val(prev_addr);
        rd_cnt++;
        last_rd_addr = prev_addr;
      end
    end
    bank_ready = rst_n && (($urandom % 3) != 0);
    prev_req   = bank_req;
    prev_we    = bank_we;
    prev_addr  = bank_addr;
    prev_wd    = bank_wdata;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input bit w, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_phy = p; acc_reg = r; acc_wdata = d;
    while (!acc_ready) @(negedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic settle();
    while (!acc_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    int w0 = wr_cnt, r0 = rd_cnt;
    logic [15:0] ea = word_of(p, r);
    logic [31:0] ed = {wsh_m, d};
    send(1'b1, p, r, d);
    settle();
    if (p == 5'h1F && r == 5'h10) begin
      page_m = d[8:0];
      check(wr_cnt == w0, "R1 page write no bank", wr_cnt, w0);
    end else if (p[4:3] == 2'b10 && r[0]) begin
      wsh_m = d;
      check(wr_cnt == w0 && rd_cnt == r0, "R3 high write no bank", wr_cnt + rd_cnt, w0 + r0);
    end else if (p[4:3] == 2'b10) begin
      check(wr_cnt == w0 + 1, "R4 one bank write", wr_cnt, w0 + 1);
      check(last_wr_data == ed, "R4 write word", last_wr_data, ed);
      check(last_wr_addr == ea, "R2 write address", last_wr_addr, ea);
    end else begin
      check(wr_cnt == w0 && rd_cnt == r0, "R7 ignored write", wr_cnt + rd_cnt, w0 + r0);
    end
  endtask

  task automatic do_read(input logic [4:0] p, input logic [4:0] r);
    int w0 = wr_cnt, r0 = rd_cnt;
    logic [15:0] ea = word_of(p, r);
    logic [15:0] exp, got;
    logic [31:0] word;
    send(1'b0, p, r, 16'h0);
    while (!rsp_valid) @(negedge clk);
    got = rsp_data;
    for (int k = 0; k < int'($urandom % 3); k++) begin
      @(negedge clk);
      check(rsp_valid && rsp_data == got && !acc_ready, "R9 response held", rsp_data, got);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    if (p == 5'h1F && r == 5'h10) begin
      exp = {7'b0, page_m};
      check(got == exp, "R1 page read", got, exp);
    end else if (p[4:3] == 2'b10 && r[0]) begin
      check(got == rsh_m, "R6 high read", got, rsh_m);
      check(rd_cnt == r0, "R6 no bank read", rd_cnt, r0);
    end else if (p[4:3] == 2'b10) begin
      word = mem_val(ea);
      rsh_m = word[31:16];
      check(got == word[15:0], "R5 low read", got, word[15:0]);
      check(rd_cnt == r0 + 1, "R5 one bank read", rd_cnt, r0 + 1);
      check(last_rd_addr == ea, "R2 read address", last_rd_addr, ea);
    end else begin
      check(got == 16'h0, "R8 unmapped read", got, 0);
      check(wr_cnt == w0 && rd_cnt == r0, "R8 no bank", rd_cnt, r0);
    end
  endtask

  function automatic logic [4:0] out_phy();
    logic [4:0] p;
    p = 5'($urandom);
    if (p[4:3] == 2'b10) p[4] = 1'b0;
    return p;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    check(acc_ready && !bank_req && !rsp_valid, "R10 reset state",
          {acc_ready, bank_req, rsp_valid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(5'h1F, 5'h10);                 // R1 page is 0 after reset
    do_write(5'h1F, 5'h10, 16'hFFA5);      // R1 loads 9 bits
    do_read(5'h1F, 5'h10);
    do_write(5'h13, 5'h0B, 16'hBEEF);      // R3
    do_write(5'h13, 5'h0A, 16'h1234);      // R4, R2
    do_read(5'h13, 5'h0A);                 // R5
    do_read(5'h13, 5'h0B);                 // R6
    do_write(5'h05, 5'h10, 16'h0033);      // R7
    do_write(5'h1F, 5'h11, 16'h0044);      // R7 next to the page pair
    do_read(5'h1F, 5'h10);                 // R7 page unchanged
    do_read(5'h1E, 5'h02);                 // R8
    do_read(5'h17, 5'h1E);                 // R5 top of window
    do_read(5'h10, 5'h01);                 // R6
    for (int i = 0; i < 600; i++) begin
      logic [4:0] p, r;
      int op = int'($urandom % 10);
      p = {2'b10, 3'($urandom)};
      r = 5'($urandom);
      case (op)
        0: do_write(5'h1F, 5'h10, 16'($urandom % 4));
        1: do_read(5'h1F, 5'h10);
        2, 3: do_write(p, {r[4:1], 1'b1}, 16'($urandom));
        4, 5: do_write(p, {r[4:1], 1'b0}, 16'($urandom));
        6: do_read(p, {r[4:1], 1'b0});
        7: do_read(p, {r[4:1], 1'b1});
        8: begin
          p = out_phy();
          if (p == 5'h1F && r == 5'h10) r = 5'h11;
          do_write(p, r, 16'($urandom));
        end
        default: begin
          p = out_phy();
          if (p == 5'h1F && r == 5'h10) r = 5'h11;
          do_read(p, r);
        end
      endcase
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule